// File: doc/BRIEF.md
# Indirect pointer address generator

This block forms the data-memory address for each access made by an 8-bit core whose data space is 12 bits wide. For a direct access, the core supplies an 8-bit offset from the instruction, an access bit and a 4-bit bank-select value. The block joins the offset to either bank 0 or the selected bank. The block also holds three 12-bit pointer registers, each able to reach the whole data space without banking.

Each pointer owns a group of eight consecutive data addresses. Five of these are aliases. When a direct address falls on an alias, the access is redirected through that pointer. Which alias was hit, and no control bit, decides what happens to the pointer:
- it is used as is;
- it is decremented after use;
- it is incremented after use;
- it is incremented before use;
- it is used with the signed working-register value added, while the pointer itself stays unchanged.

The effective address is produced in the same cycle as the request. The pointer side effects commit on the clock edge that completes the access. A separate load port writes a pointer value directly. The memory array and the ALU sit outside this block.

Top module: `ptr_addr_gen`

## Requirements
- R1: With `acc_en`=1, `a_bit`=0 and a non-alias address, `ea` = {4'h0, `ofs`}, `ind` = 0 and `void_acc` = 0.
- R2: With `a_bit`=1 and a non-alias address, `ea` = {`bsr`, `ofs`}.
- R3: After reset all three pointers read 0 on `ptrs` (pointer k sits at bits 12k+11:12k). A load (`ld_en`=1, `ld_sel`=k<3) places `ld_val` in pointer k at the next edge. `ld_sel`=3 changes nothing.
- R4: The alias window starts at 0x0E0. Pointer k owns 0x0E0+8k .. 0x0E7+8k, with the mode given by the low 3 bits. Mode 0 (plain) gives `ea` = pointer and leaves the pointer unchanged.
- R5: Mode 1 (post-decrement) gives `ea` = pointer, and the pointer becomes pointer-1 modulo 4096 at the edge.
- R6: Mode 2 (post-increment) gives `ea` = pointer, and the pointer becomes pointer+1 modulo 4096 at the edge.
- R7: Mode 3 (pre-increment) gives `ea` = pointer+1 modulo 4096, and the pointer takes that same value at the edge.
- R8: Mode 4 (W-indexed) gives `ea` = pointer + sign-extended `wreg`, modulo 4096, and the pointer is unchanged.
- R9: `ind` is 1 exactly when an access hits one of the 15 alias addresses. Group offsets 5..7 and all addresses outside 0x0E0..0x0F7 act as plain direct addresses.
- R10: `void_acc` is 1 exactly when an indirect access produces an `ea` that is itself an alias address. The pointer side effect still commits in that case.
- R11: Only the pointer named by the alias changes. With `acc_en`=0 and no load, no pointer changes.
- R12: When a load and an auto-modify target the same pointer on the same edge, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | An access is made this cycle |
| a_bit | input | 1 | 0: bank 0, 1: bank from `bsr` |
| bsr | input | 4 | Bank-select value |
| ofs | input | 8 | Instruction offset |
| wreg | input | 8 | Working register (signed in W-indexed mode) |
| ld_en | input | 1 | Load a pointer |
| ld_sel | input | 2 | Pointer to load |
| ld_val | input | 12 | Value to load |
| ea | output | 12 | Effective address |
| ind | output | 1 | Access is indirect |
| void_acc | output | 1 | Indirect target is an alias: read 0, no write |
| ptrs | output | 36 | Current pointer values, pointer k at [12k+11:12k] |

## Verification
`ea`, `ind` and `void_acc` are combinational and are due in the cycle the request is presented. The bench drives each request on the falling edge and samples these outputs 2 ns later, well before the next rising edge. Pointer updates and loads appear on `ptrs` one rising edge after the request, so the bench samples them 2 ns after that edge, against a model it has already advanced. The sweep covers every pointer, all eight group offsets, pointer values at the wrap points and inside the alias window, and working-register values around the sign boundary.

// File: rtl/ptr_addr_gen.sv
module ptr_addr_gen #(
  parameter int BANKW = 4,
  parameter int OFSW = 8,
  parameter int NPTR = 3,
  parameter int WW = 8,
  parameter logic [BANKW+OFSW-1:0] ALIAS_BASE = 'h0E0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic                   a_bit,
  input  logic [BANKW-1:0]       bsr,
  input  logic [OFSW-1:0]        ofs,
  input  logic [WW-1:0]          wreg,
  input  logic                   ld_en,
  input  logic [1:0]             ld_sel,
  input  logic [BANKW+OFSW-1:0]  ld_val,
  output logic [BANKW+OFSW-1:0]  ea,
  output logic                   ind,
  output logic                   void_acc,
  output logic [NPTR*(BANKW+OFSW)-1:0] ptrs
);
  localparam int AW = BANKW + OFSW;
  localparam int GRP = 8;
  localparam int WIN = GRP * NPTR;
  localparam logic [2:0] M_PLAIN = 3'd0, M_PDEC = 3'd1, M_PINC = 3'd2,
                         M_PREI = 3'd3, M_PLUSW = 3'd4;

  function automatic logic is_alias(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a - ALIAS_BASE;
    return (a >= ALIAS_BASE) && (r < AW'(WIN)) && (r[2:0] <= M_PLUSW);
  endfunction

  logic [AW-1:0] ptr_r [NPTR];
  logic [AW-1:0] dir_addr, rel, cur, ea_ind, nxt, wext;
  logic [1:0]    sel;
  logic [2:0]    mode;
  logic          hit;

  assign dir_addr = a_bit ? {bsr, ofs} : {BANKW'(0), ofs};
  assign rel      = dir_addr - ALIAS_BASE;
  assign sel      = rel[4:3];
  assign mode     = rel[2:0];
  assign hit      = acc_en && is_alias(dir_addr);
  assign wext     = {{(AW-WW){wreg[WW-1]}}, wreg};

  always_comb begin
    cur = '0;
    for (int i = 0; i < NPTR; i++)
      if (sel == 2'(i)) cur = ptr_r[i];
  end

  always_comb begin
    case (mode)
      M_PREI:  ea_ind = cur + AW'(1);
      M_PLUSW: ea_ind = cur + wext;
      default: ea_ind = cur;
    endcase
    case (mode)
      M_PDEC:  nxt = cur - AW'(1);
      M_PINC,
      M_PREI:  nxt = cur + AW'(1);
      default: nxt = cur;
    endcase
  end

  assign ea       = hit ? ea_ind : dir_addr;
  assign ind      = hit;
  assign void_acc = hit && is_alias(ea_ind);

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPTR; i++) begin
      if (!rst_n)
        ptr_r[i] <= '0;
      else if (ld_en && ld_sel == 2'(i))
        ptr_r[i] <= ld_val;
      else if (hit && sel == 2'(i))
        ptr_r[i] <= nxt;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPTR; g++) begin : g_ptr
      assign ptrs[g*AW +: AW] = ptr_r[g];

      // R5
      pdec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel == 2'(g) && mode == M_PDEC && !(ld_en && ld_sel == 2'(g)))
        |=> ptr_r[g] == $past(ptr_r[g]) - AW'(1));

      // R7
      prei_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel == 2'(g) && mode == M_PREI && !(ld_en && ld_sel == 2'(g)))
        |=> ptr_r[g] == $past(ea));

      // R8
      plusw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sel == 2'(g) && mode == M_PLUSW && !(ld_en && ld_sel == 2'(g)))
        |=> $stable(ptr_r[g]));

      // R11
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !ld_en) |=> $stable(ptr_r[g]));

      // R12
      ldwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_sel == 2'(g)) |=> ptr_r[g] == $past(ld_val));
    end
  endgenerate

  // R10
  void_chk: assert property (@(posedge clk) disable iff (!rst_n)
    void_acc |-> ind);

  // R1
  bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !ind && !a_bit) |-> ea[AW-1:OFSW] == '0);
endmodule

// File: tb/ptr_addr_gen_test.sv
module ptr_addr_gen_test;
  logic clk = 0, rst_n = 0;
  logic acc_en = 0, a_bit = 0, ld_en = 0;
  logic [3:0] bsr = 0;
  logic [7:0] ofs = 0, wreg = 0;
  logic [1:0] ld_sel = 0;
  logic [11:0] ld_val = 0;
  logic [11:0] ea;
  logic ind, void_acc;
  logic [35:0] ptrs;

  int vec = 0, bad = 0;
  logic [11:0] mp [3];
  bit done = 0;

  always #10 clk = ~clk;

  ptr_addr_gen uut (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .a_bit(a_bit),
    .bsr(bsr), .ofs(ofs), .wreg(wreg), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_val(ld_val), .ea(ea), .ind(ind), .void_acc(void_acc), .ptrs(ptrs));

  function automatic bit m_alias(input logic [11:0] a);
    logic [11:0] r;
    r = a - 12'h0E0;
    return a >= 12'h0E0 && r < 12'd24 && r[2:0] <= 3'd4;
  endfunction

  task automatic chk(input string tg, input logic [11:0] act, input logic [11:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tg, act, exp);
    end
  endtask

  task automatic chk_ptrs(input string tg);
    for (int k = 0; k < 3; k++) chk(tg, ptrs[k*12 +: 12], mp[k]);
  endtask

  task automatic step(input bit acc, input bit a, input logic [3:0] b,
                      input logic [7:0] o, input logic [7:0] w,
                      input bit ld, input logic [1:0] ls, input logic [11:0] lv);
    logic [11:0] dir, r, cur, e, n;
    logic [1:0] k;
    logic [2:0] m;
    bit h;
    string tg;
    @(negedge clk);
    acc_en = acc; a_bit = a; bsr = b; ofs = o; wreg = w;
    ld_en = ld; ld_sel = ls; ld_val = lv;
    dir = a ? {b, o} : {4'h0, o};
    h = acc && m_alias(dir);
    r = dir - 12'h0E0; k = r[4:3]; m = r[2:0];
    cur = (k < 3) ? mp[k] : 12'h0;
    e = dir; n = cur; tg = a ? "R2" : "R1";
    if (h) begin
      case (m)
        3'd0: begin e = cur;                         tg = "R4"; end
        3'd1: begin e = cur; n = cur - 12'd1;        tg = "R5"; end
        3'd2: begin e = cur; n = cur + 12'd1;        tg = "R6"; end
        3'd3: begin e = cur + 12'd1; n = e;          tg = "R7"; end
        default: begin e = cur + {{4{w[7]}}, w};     tg = "R8"; end
      endcase
    end
    #2;
    if (acc) begin
      chk(tg, ea, e);
      chk("R9", {11'b0, ind}, {11'b0, h});
      chk("R10", {11'b0, void_acc}, {11'b0, h && m_alias(e)});
    end
    @(posedge clk);
    if (h) mp[k] = n;
    if (ld && ls < 3) mp[ls] = lv;
    if (ld && h && ls == k) tg = "R12";
    else if (!acc && !ld) tg = "R11";
    else if (ld) tg = "R3";
    #2;
    chk_ptrs(tg);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pv [7];
    logic [7:0] wv [5];
    pv = '{12'h000, 12'h001, 12'h7FF, 12'hFFF, 12'h0DF, 12'h0E3, 12'h0EB};
    wv = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    for (int k = 0; k < 3; k++) mp[k] = 12'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk_ptrs("R3");
    // R1 R2 R9: direct sweep
    for (int o = 0; o < 256; o++) begin
      step(1, 0, 4'h0, 8'(o), 8'h00, 0, 0, 0);
      step(1, 1, 4'h5, 8'(o), 8'h00, 0, 0, 0);
      step(1, 1, 4'hF, 8'(o), 8'h00, 0, 0, 0);
    end
    // R4..R10: pointer x mode x value x wreg sweep
    for (int k = 0; k < 3; k++)
      for (int m = 0; m < 8; m++)
        for (int p = 0; p < 7; p++)
          for (int j = 0; j < 5; j++) begin
            step(0, 0, 0, 0, 0, 1, 2'(k), pv[p] ^ 12'(k));
            step(1, 0, 4'h0, 8'(8'hE0 + 8 * k + m), wv[j], 0, 0, 0);
          end
    // R3: ld_sel 3 ignored, R11 idle cycles
    step(0, 0, 0, 0, 0, 1, 2'd3, 12'hABC);
    step(0, 1, 4'h0, 8'hE1, 8'h00, 0, 0, 0);
    step(0, 1, 4'h0, 8'hE9, 8'h00, 0, 0, 0);
    // R2 via a_bit=1 bank 0 aliases
    step(1, 1, 4'h0, 8'hF2, 8'h00, 0, 0, 0);
    // R12: load collides with auto-modify
    step(1, 0, 4'h0, 8'hE2, 8'h00, 1, 2'd0, 12'h123);
    step(1, 0, 4'h0, 8'hF1, 8'h00, 1, 2'd2, 12'h456);
    step(1, 0, 4'h0, 8'hEB, 8'h00, 1, 2'd0, 12'h789);
    // R11: access to one pointer while another loads
    step(1, 0, 4'h0, 8'hEA, 8'h00, 1, 2'd2, 12'hFFF);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule